// File: doc/BRIEF.md
# Pedestrian Crossing Light Sequencer

This block sequences the lamps of a pedestrian crossing on a road. It drives three road lamps (green, amber, red), a wait sign for pedestrians, and the two pedestrian figures: walk (green) and do-not-walk (red). The controller rests with the road green and the red figure lit. A button press starts a request. The road then stays green until a road sensor has reported clear for one whole check window. After that the road shows amber, then red while pedestrians cross. Next comes a flashing phase with a fixed number of on/off pairs, and the controller then returns to rest.

All time is counted in ticks of a one-cycle tick-enable input, nominally one per millisecond. Every duration and the flash count are parameters. The lamp outputs decode straight from the phase register, so no lamp output glitches in the middle of a phase.

Top module: `ped_xing_seq`

## Requirements
- R1: At rest (phase NORMAL) exactly road green and the do-not-walk figure are lit; all other lamps are off.
- R2: A high `req_i` at a clock edge in NORMAL moves the block to the request phase, whether or not a tick occurs. In the request phase road green, the wait sign and do-not-walk are lit.
- R3: The request phase ends after `CHECK_TICKS` consecutive ticks during which `road_clear_i` was high. A cycle with `road_clear_i` low restarts the count from zero. Road amber follows at the edge of the final tick.
- R4: The amber phase lights road amber, the wait sign and do-not-walk, and lasts exactly `AMBER_TICKS` ticks.
- R5: The crossing phase lights road red and walk, with the wait sign off, and lasts exactly `CROSS_TICKS` ticks.
- R6: A flash pair is road amber with walk for `HALF_TICKS` ticks, followed by all lamps off for `HALF_TICKS` ticks.
- R7: Exactly `FLASH_REPS` flash pairs follow the crossing phase. The edge that ends the last dark half returns the block to NORMAL.
- R8: `req_i` has no effect in any phase other than NORMAL.
- R9: While `rst_ni` is low the block is in NORMAL, with the flash count, the sensor window and the phase timer all cleared. A reset in the middle of a sequence gives a later sequence the full number of flashes.
- R10: Outside NORMAL the phase changes only at an edge where `tick_i` is high. Cycles without a tick do not advance any timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| req_i | input | 1 | Pedestrian request button |
| road_clear_i | input | 1 | Road sensor reports no traffic |
| road_grn_o | output | 1 | Road green lamp |
| road_amb_o | output | 1 | Road amber lamp |
| road_red_o | output | 1 | Road red lamp |
| wait_o | output | 1 | Wait sign |
| walk_o | output | 1 | Pedestrian walk figure |
| dont_walk_o | output | 1 | Pedestrian do-not-walk figure |

## Verification
The bench builds the block with a 3-tick sensor window, a 2-tick amber phase, a 3-tick crossing phase, 1-tick flash halves and 3 flash pairs. With these values a whole crossing cycle fits in about twenty cycles, so every phase boundary can be checked one cycle at a time. The bench also drops the sensor input partway through a window, withholds ticks for some cycles, presses the button in phases where it must be ignored, and resets the block while it is flashing.

// File: rtl/ped_xing_pkg.sv
package ped_xing_pkg;

  typedef enum logic [2:0] {
    PH_NORMAL = 3'd0,
    PH_REQ    = 3'd1,
    PH_AMBER  = 3'd2,
    PH_CROSS  = 3'd3,
    PH_FON    = 3'd4,
    PH_FOFF   = 3'd5
  } phase_e;

endpackage

// File: rtl/ped_xing_sensor_win.sv
module ped_xing_sensor_win #(
  parameter int CHECK_TICKS = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic clear_i,
  output logic pass_o
);

  localparam int CW = $clog2(CHECK_TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign pass_o = en_i && clear_i && tick_i && (cnt_q == CW'(CHECK_TICKS - 1));

  // any cycle without a clear road restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !clear_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= pass_o ? '0 : cnt_q + 1'b1;
  end

  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(CHECK_TICKS)); // R3

  AST_WIN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> cnt_q == '0); // R3

endmodule

// File: rtl/ped_xing_timer.sv
module ped_xing_timer #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  assign done_o = en_i && tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || restart_i)  cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < limit_i); // R4

  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && en_i && !restart_i) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/ped_xing_flash_cnt.sv
module ped_xing_flash_cnt #(
  parameter int FLASH_REPS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int FW = $clog2(FLASH_REPS + 1);

  logic [FW-1:0] cnt_q;

  assign last_o = (cnt_q == FW'(FLASH_REPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  AST_FLASH_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < FW'(FLASH_REPS)); // R7

endmodule

// File: rtl/ped_xing_lamps.sv
module ped_xing_lamps
  import ped_xing_pkg::*;
(
  input  phase_e phase_i,
  output logic   road_grn_o,
  output logic   road_amb_o,
  output logic   road_red_o,
  output logic   wait_o,
  output logic   walk_o,
  output logic   dont_walk_o
);

  logic [5:0] lamps;

  // {grn, amb, red, wait, walk, dont_walk}
  always_comb begin
    unique case (phase_i)
      PH_NORMAL: lamps = 6'b100001;
      PH_REQ:    lamps = 6'b100101;
      PH_AMBER:  lamps = 6'b010101;
      PH_CROSS:  lamps = 6'b001010;
      PH_FON:    lamps = 6'b010010;
      PH_FOFF:   lamps = 6'b000000;
      default:   lamps = 6'b100001;
    endcase
  end

  assign {road_grn_o, road_amb_o, road_red_o, wait_o, walk_o, dont_walk_o} = lamps;

endmodule

// File: rtl/ped_xing_seq.sv
module ped_xing_seq
  import ped_xing_pkg::*;
#(
  parameter int CHECK_TICKS = 5000,
  parameter int AMBER_TICKS = 4000,
  parameter int CROSS_TICKS = 10000,
  parameter int HALF_TICKS  = 500,
  parameter int FLASH_REPS  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  logic road_clear_i,
  output logic road_grn_o,
  output logic road_amb_o,
  output logic road_red_o,
  output logic wait_o,
  output logic walk_o,
  output logic dont_walk_o
);

  localparam int MAX_AC = (AMBER_TICKS > CROSS_TICKS) ? AMBER_TICKS : CROSS_TICKS;
  localparam int MAX_T  = (MAX_AC > HALF_TICKS) ? MAX_AC : HALF_TICKS;
  localparam int TW     = $clog2(MAX_T + 1);

  phase_e        phase_q, phase_d;
  logic          win_pass, tmr_done, tmr_en, tmr_restart;
  logic          flash_last, flash_clr, flash_inc;
  logic [TW-1:0] tmr_limit;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_NORMAL: if (req_i)    phase_d = PH_REQ;
      PH_REQ:    if (win_pass) phase_d = PH_AMBER;
      PH_AMBER:  if (tmr_done) phase_d = PH_CROSS;
      PH_CROSS:  if (tmr_done) phase_d = PH_FON;
      PH_FON:    if (tmr_done) phase_d = PH_FOFF;
      PH_FOFF:   if (tmr_done) phase_d = flash_last ? PH_NORMAL : PH_FON;
      default:   phase_d = PH_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_NORMAL;
    else         phase_q <= phase_d;
  end

  always_comb begin
    unique case (phase_q)
      PH_AMBER:        tmr_limit = TW'(AMBER_TICKS);
      PH_CROSS:        tmr_limit = TW'(CROSS_TICKS);
      PH_FON, PH_FOFF: tmr_limit = TW'(HALF_TICKS);
      default:         tmr_limit = TW'(MAX_T);
    endcase
  end

  assign tmr_en      = (phase_q == PH_AMBER) || (phase_q == PH_CROSS) ||
                       (phase_q == PH_FON)   || (phase_q == PH_FOFF);
  assign tmr_restart = (phase_d != phase_q);
  assign flash_clr   = !((phase_q == PH_FON) || (phase_q == PH_FOFF));
  assign flash_inc   = (phase_q == PH_FOFF) && tmr_done;

  ped_xing_sensor_win #(.CHECK_TICKS(CHECK_TICKS)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (phase_q == PH_REQ),
    .tick_i  (tick_i),
    .clear_i (road_clear_i),
    .pass_o  (win_pass)
  );

  ped_xing_timer #(.W(TW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tmr_en),
    .restart_i (tmr_restart),
    .tick_i    (tick_i),
    .limit_i   (tmr_limit),
    .done_o    (tmr_done)
  );

  ped_xing_flash_cnt #(.FLASH_REPS(FLASH_REPS)) u_flash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flash_clr),
    .inc_i  (flash_inc),
    .last_o (flash_last)
  );

  ped_xing_lamps u_lamps (
    .phase_i     (phase_q),
    .road_grn_o  (road_grn_o),
    .road_amb_o  (road_amb_o),
    .road_red_o  (road_red_o),
    .wait_o      (wait_o),
    .walk_o      (walk_o),
    .dont_walk_o (dont_walk_o)
  );

  AST_ROAD_ONE_LAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({road_grn_o, road_amb_o, road_red_o}) <= 1); // R1

  AST_WALK_NOT_ON_GREEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(walk_o && (road_grn_o || dont_walk_o))); // R5

  AST_REST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NORMAL && !req_i) |=> phase_q == PH_NORMAL); // R2

  AST_REQ_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REQ && !(road_clear_i && tick_i)) |=> phase_q == PH_REQ); // R3

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && phase_q != PH_NORMAL) |=> $stable(phase_q)); // R10

  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CROSS) |=> phase_q inside {PH_CROSS, PH_FON}); // R8

endmodule

// File: tb/ped_xing_seq_test.sv
module ped_xing_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, req = 1'b0, clr = 1'b0;
  logic grn, amb, red, wt, walk, dwalk;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  ped_xing_seq #(
    .CHECK_TICKS(3), .AMBER_TICKS(2), .CROSS_TICKS(3),
    .HALF_TICKS(1), .FLASH_REPS(3)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .road_clear_i(clr),
    .road_grn_o(grn), .road_amb_o(amb), .road_red_o(red),
    .wait_o(wt), .walk_o(walk), .dont_walk_o(dwalk)
  );

  localparam logic [5:0] L_NORM = 6'b100001;
  localparam logic [5:0] L_REQ  = 6'b100101;
  localparam logic [5:0] L_AMB  = 6'b010101;
  localparam logic [5:0] L_CRS  = 6'b001010;
  localparam logic [5:0] L_FON  = 6'b010010;
  localparam logic [5:0] L_FOFF = 6'b000000;

  // {tick, req, clear, lamps expected after the edge}
  localparam logic [8:0] VEC [22] = '{
    {3'b100, L_NORM},  // R1 idle
    {3'b110, L_REQ},   // R2 press
    {3'b101, L_REQ},   // R3 window 1
    {3'b101, L_REQ},   // R3 window 2
    {3'b100, L_REQ},   // R3 drop restarts
    {3'b101, L_REQ},   // R3 window 1
    {3'b001, L_REQ},   // R10 no tick
    {3'b111, L_REQ},   // R8 press in request
    {3'b101, L_AMB},   // R3 window complete
    {3'b110, L_AMB},   // R4 amber tick 1, R8 press
    {3'b100, L_CRS},   // R4 amber done
    {3'b100, L_CRS},   // R5 cross 1
    {3'b000, L_CRS},   // R10 no tick
    {3'b100, L_CRS},   // R5 cross 2
    {3'b100, L_FON},   // R5 cross done
    {3'b100, L_FOFF},  // R6 pair 1
    {3'b100, L_FON},   // R7
    {3'b110, L_FOFF},  // R8 press while flashing
    {3'b100, L_FON},   // R7
    {3'b100, L_FOFF},  // R6 pair 3
    {3'b100, L_NORM},  // R7 back to rest
    {3'b110, L_REQ}    // R2 new request
  };

  function automatic string row_tag(int i);
    case (i)
      0:                  return "R1";
      1, 21:              return "R2";
      2, 3, 4, 5, 8:      return "R3";
      6, 12:              return "R10";
      7, 9, 17:           return "R8";
      10:                 return "R4";
      11, 13, 14:         return "R5";
      15, 19:             return "R6";
      default:            return "R7";
    endcase
  endfunction

  function automatic logic [5:0] lamps();
    return {grn, amb, red, wt, walk, dwalk};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic t, logic r, logic c);
    @(negedge clk);
    tick = t; req = r; clr = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n_fon;
    int edges;
    logic [5:0] prev;
    repeat (3) @(posedge clk);
    #1 check("R9 reset lamps", 32'(lamps()), 32'(L_NORM));
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 22; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6]);
      check(row_tag(i), 32'(lamps()), 32'(VEC[i][5:0]));
    end

    // drive into the flashing phase, then reset asynchronously
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b1);
    check("R6 flashing before reset", 32'(lamps() == L_FON || lamps() == L_FOFF), 32'd1);
    #4 rst_n = 1'b0;
    #1 check("R9 async reset", 32'(lamps()), 32'(L_NORM));
    @(negedge clk) rst_n = 1'b1;

    // full cycle after reset: flash count starts fresh
    step(1'b1, 1'b1, 1'b1);
    check("R2 request after reset", 32'(lamps()), 32'(L_REQ));
    n_fon = 0;
    edges = 0;
    prev = lamps();
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 1'b1);
      edges++;
      if (lamps() == L_FON && prev != L_FON) n_fon++;
      prev = lamps();
      if (lamps() == L_NORM) break;
    end
    check("R7 flash pairs", 32'(n_fon), 32'd3);
    check("R9 cycle length", 32'(edges), 32'd14);

    // resting block holds without a request
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    check("R1 rest holds", 32'(lamps()), 32'(L_NORM));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule